// File: doc/BRIEF.md
# Multi-Byte Register Transfer Sequencer for a Two-Wire Bus

This block turns one register-level request into a series of byte-level commands for a two-wire serial bus engine. The request names a target, a starting register offset, a byte count and a direction. It gets the data it needs through two streams: bytes to write come in on one, and bytes read back go out on the other. The bit-level engine that drives the wires sits beside this block. For every command it accepts, it returns exactly one response. For a byte write, the response says whether the target acknowledged. For a byte read, the response carries the byte that was received.

A read first sets the register pointer in the target and then switches to read mode with a repeated START. A write is cut into short chunks, and each chunk is a complete bus transaction of its own. After a chunk, the target is busy with its internal write cycle. The block waits for it by repeatedly addressing the target until it acknowledges, up to a fixed number of tries. A compact addressing mode is also available, in which the offset takes the place of the target byte. Each request finishes with a one-cycle `done` pulse and a pass or fail flag.

Stream rules: `wr_data` is taken on a cycle where both `wr_valid` and `wr_ready` are high. Once `wr_valid` is raised, the source keeps it and the data steady until they are taken. `rd_valid` with `rd_data` stays stable until `rd_ready` is high. While it waits, the bus sequence stalls. `cmd_valid` and its fields stay stable until `cmd_ready` is high. The one exception is while the block is waiting for write data. Responses are pulses on `rsp_valid`, with no back-pressure.

Top module: `i2cblk_seq`

## Requirements
- R1: Normal read. The block sends WR(START, {dev,0}), then WR(offset). It then waits at least GAP_CYCLES cycles after the offset response. It then sends WR(START, {dev,1}), with no STOP anywhere in this sequence.
- R2: Compact read. Only one addressing command is sent: WR(START, {offset[6:0],1}). The data reads follow it directly.
- R3: Read bytes are issued as RD commands. `cmd_last`=1 only on the final byte, which means the block answers that byte with NACK followed by STOP. Received bytes appear on the read stream in order and are held under back-pressure.
- R4: A NACK on any addressing or offset byte is followed by exactly one STOP command. The request then ends with done=1 and ok=0.
- R5: A write is sent as chunks of at most CHUNK bytes. Each chunk re-sends its addressing using the current offset. That offset has been moved forward by all earlier chunks and wraps modulo 256. Each chunk ends with a STOP.
- R6: After each chunk, the block polls with WR(START, {dev,1}). A NACK on a poll is followed by a STOP and another poll. After MAX_POLL polls have all been NACKed, the request fails without a further command.
- R7: An acknowledged poll is followed by one RD command with `cmd_last`=1. The byte it returns is discarded and never appears on the read stream.
- R8: A NACK on a write data byte is followed by STOP and a failed result. No further write bytes are taken from the stream.
- R9: A request with length zero raises done=1 with ok=1 in the cycle after `go` is accepted. It issues no command.
- R10: Compact write. Each chunk is addressed by the single command WR(START, {offset[6:0],0}).
- R11: Command encodings are `cmd_kind` 0 = byte write, 1 = byte read, 2 = STOP. A response has `rsp_ack`=1 for an acknowledge. A pending command holds its fields until it is accepted. A pending read byte holds its value until it is taken.
- R12: `go` is ignored while `busy` is high.
- R13: After reset the block is idle. No valid or ready output is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Request start, accepted only when idle |
| is_read | input | 1 | 1 = read request, 0 = write request |
| legacy | input | 1 | 1 = compact addressing, offset replaces the target byte |
| dev_addr | input | 7 | Target address, sent in bits 7:1 of the address byte |
| reg_off | input | 8 | Starting register offset |
| xfer_len | input | LEN_W | Byte count of the request |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Result of the last request, valid while done is high |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Write stream byte taken this cycle |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read stream byte available |
| rd_ready | input | 1 | Read stream sink accepts |
| rd_data | output | 8 | Read stream byte |
| cmd_valid | output | 1 | Command to the byte engine is pending |
| cmd_ready | input | 1 | Byte engine accepts the command |
| cmd_kind | output | 2 | 0 byte write, 1 byte read, 2 STOP |
| cmd_start | output | 1 | Precede the byte write with a START or repeated START |
| cmd_last | output | 1 | On a byte read, answer with NACK and then STOP |
| cmd_byte | output | 8 | Byte to send |
| rsp_valid | input | 1 | Engine finished the last accepted command |
| rsp_ack | input | 1 | Target acknowledged the written byte |
| rsp_byte | input | 8 | Byte received by a read command |

## Verification
Every outcome in this block can be tied to a specific clock edge. A command shows up on the cycle of its handshake. The next command cannot appear until one cycle after the response for the previous one. A read byte is presented one cycle after its response and stays there until taken. The `done` pulse is one cycle after the response that ends the request, or one cycle after `go` when the length is zero. The bench plays the role of the engine and the target, holding a queue of expected commands built from the requirements. At each predicted handshake it compares the command fields and answers after a fixed latency. It times the repeated-START gap from the cycle of the offset response, checks zero-length completion at exactly one cycle after `go`, and at the end of each request compares the result, the leftover queues and the number of write bytes consumed.

// File: rtl/i2cblk_pkg.sv
package i2cblk_pkg;

  typedef enum logic [1:0] {
    K_WR   = 2'd0,
    K_RD   = 2'd1,
    K_STOP = 2'd2
  } kind_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ADDR,   // first addressing byte with START
    PH_OFF,    // register offset byte
    PH_GAP,    // bus-free wait before repeated START
    PH_RADDR,  // repeated START with read bit
    PH_RDATA,  // read one data byte
    PH_RPUSH,  // hand the byte to the read stream
    PH_WDATA,  // write one data byte
    PH_CSTOP,  // chunk closing STOP
    PH_POLL,   // completion poll address
    PH_PSTOP,  // STOP after a refused poll
    PH_PREAD,  // discard read after accepted poll
    PH_FSTOP   // STOP before failing
  } phase_e;

endpackage

// File: rtl/i2cblk_cmd_gen.sv
module i2cblk_cmd_gen
  import i2cblk_pkg::*;
(
  input  phase_e     phase,
  input  logic       legacy,
  input  logic       is_read,
  input  logic [6:0] dev,
  input  logic [7:0] off,
  input  logic [7:0] wbyte,
  input  logic       last_read,
  output logic       active,
  output kind_e      kind,
  output logic       start,
  output logic       last,
  output logic [7:0] byte_o
);

  always_comb begin
    active = 1'b1;
    kind   = K_WR;
    start  = 1'b0;
    last   = 1'b0;
    byte_o = 8'h00;
    unique case (phase)
      PH_ADDR: begin
        start  = 1'b1;
        byte_o = legacy ? {off[6:0], is_read} : {dev, 1'b0};
      end
      PH_OFF:   byte_o = off;
      PH_RADDR, PH_POLL: begin
        start  = 1'b1;
        byte_o = {dev, 1'b1};
      end
      PH_WDATA: byte_o = wbyte;
      PH_RDATA: begin
        kind = K_RD;
        last = last_read;
      end
      PH_PREAD: begin
        kind = K_RD;
        last = 1'b1;
      end
      PH_CSTOP, PH_PSTOP, PH_FSTOP: kind = K_STOP;
      default: active = 1'b0;
    endcase
  end

endmodule

// File: rtl/i2cblk_gap_timer.sv
module i2cblk_gap_timer #(
  parameter int CYCLES = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int W = $clog2(CYCLES + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= W'(CYCLES);
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign expired = (cnt_q == '0);

  // R1: the wait cannot be over on the cycle right after it was armed
  a_r1_gap_armed: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired);

endmodule

// File: rtl/i2cblk_poll_ctr.sv
module i2cblk_poll_ctr #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic spent
);

  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (bump && cnt_q != W'(LIMIT)) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign spent = (cnt_q == W'(LIMIT));

  // R6: a refused poll moves the count up by one until the limit
  a_r6_poll_step: assert property (@(posedge clk) disable iff (!rst_n)
    bump && !clear && !spent |=> cnt_q == $past(cnt_q) + W'(1));

endmodule

// File: rtl/i2cblk_seq.sv
module i2cblk_seq
  import i2cblk_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int CHUNK      = 4,
  parameter int MAX_POLL   = 100,
  parameter int GAP_CYCLES = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             is_read,
  input  logic             legacy,
  input  logic [6:0]       dev_addr,
  input  logic [7:0]       reg_off,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             busy,
  output logic             done,
  output logic             ok,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_kind,
  output logic             cmd_start,
  output logic             cmd_last,
  output logic [7:0]       cmd_byte,
  input  logic             rsp_valid,
  input  logic             rsp_ack,
  input  logic [7:0]       rsp_byte
);

  localparam int CHK_W = $clog2(CHUNK + 1);

  phase_e           phase_q;
  logic             inflight_q;
  logic [LEN_W-1:0] rem_q;
  logic [CHK_W-1:0] chk_q;
  logic [7:0]       off_q;
  logic [6:0]       dev_q;
  logic             leg_q;
  logic             rd_q;
  logic [7:0]       rbuf_q;
  logic             done_q;
  logic             ok_q;

  logic  gen_active;
  kind_e gen_kind;
  logic  gen_start;
  logic  gen_last;
  logic [7:0] gen_byte;
  logic  cmd_fire;
  logic  rsp_take;
  logic  gap_load;
  logic  gap_done;
  logic  poll_clear;
  logic  poll_bump;
  logic  poll_spent;

  function automatic logic [CHK_W-1:0] chunk_of(input logic [LEN_W-1:0] n);
    if (32'(n) > CHUNK) return CHK_W'(CHUNK);
    return CHK_W'(n);
  endfunction

  i2cblk_cmd_gen u_gen (
    .phase     (phase_q),
    .legacy    (leg_q),
    .is_read   (rd_q),
    .dev       (dev_q),
    .off       (off_q),
    .wbyte     (wr_data),
    .last_read (rem_q == LEN_W'(1)),
    .active    (gen_active),
    .kind      (gen_kind),
    .start     (gen_start),
    .last      (gen_last),
    .byte_o    (gen_byte)
  );

  i2cblk_gap_timer #(.CYCLES(GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .run     (phase_q == PH_GAP),
    .expired (gap_done)
  );

  i2cblk_poll_ctr #(.LIMIT(MAX_POLL)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (poll_clear),
    .bump  (poll_bump),
    .spent (poll_spent)
  );

  assign cmd_valid  = gen_active && !inflight_q && (phase_q != PH_WDATA || wr_valid);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign wr_ready   = (phase_q == PH_WDATA) && !inflight_q && cmd_ready;
  assign rsp_take   = rsp_valid && inflight_q;
  assign cmd_kind   = gen_kind;
  assign cmd_start  = gen_start;
  assign cmd_last   = gen_last;
  assign cmd_byte   = gen_byte;
  assign gap_load   = rsp_take && (phase_q == PH_OFF) && rsp_ack && rd_q;
  assign poll_clear = rsp_take && (phase_q == PH_CSTOP);
  assign poll_bump  = rsp_take && (phase_q == PH_POLL) && !rsp_ack;
  assign rd_valid   = (phase_q == PH_RPUSH);
  assign rd_data    = rbuf_q;
  assign busy       = (phase_q != PH_IDLE);
  assign done       = done_q;
  assign ok         = ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      inflight_q <= 1'b0;
      rem_q      <= '0;
      chk_q      <= '0;
      off_q      <= '0;
      dev_q      <= '0;
      leg_q      <= 1'b0;
      rd_q       <= 1'b0;
      rbuf_q     <= '0;
      done_q     <= 1'b0;
      ok_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cmd_fire) inflight_q <= 1'b1;
      if (rsp_take) inflight_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (go) begin
          rd_q  <= is_read;
          leg_q <= legacy;
          dev_q <= dev_addr;
          off_q <= reg_off;
          rem_q <= xfer_len;
          chk_q <= chunk_of(xfer_len);
          if (xfer_len == '0) begin
            done_q <= 1'b1;
            ok_q   <= 1'b1;
          end else begin
            phase_q <= PH_ADDR;
          end
        end
        PH_ADDR: if (rsp_take) begin
          if (!rsp_ack)   phase_q <= PH_FSTOP;
          else if (!leg_q) phase_q <= PH_OFF;
          else            phase_q <= rd_q ? PH_RDATA : PH_WDATA;
        end
        PH_OFF: if (rsp_take) begin
          if (!rsp_ack) phase_q <= PH_FSTOP;
          else          phase_q <= rd_q ? PH_GAP : PH_WDATA;
        end
        PH_GAP: if (gap_done) phase_q <= PH_RADDR;
        PH_RADDR: if (rsp_take) phase_q <= rsp_ack ? PH_RDATA : PH_FSTOP;
        PH_RDATA: if (rsp_take) begin
          rbuf_q  <= rsp_byte;
          rem_q   <= rem_q - LEN_W'(1);
          phase_q <= PH_RPUSH;
        end
        PH_RPUSH: if (rd_ready) begin
          if (rem_q == '0) begin
            done_q  <= 1'b1;
            ok_q    <= 1'b1;
            phase_q <= PH_IDLE;
          end else begin
            phase_q <= PH_RDATA;
          end
        end
        PH_WDATA: if (rsp_take) begin
          if (!rsp_ack) begin
            phase_q <= PH_FSTOP;
          end else begin
            rem_q <= rem_q - LEN_W'(1);
            chk_q <= chk_q - CHK_W'(1);
            off_q <= off_q + 8'd1;
            if (chk_q == CHK_W'(1)) phase_q <= PH_CSTOP;
          end
        end
        PH_CSTOP: if (rsp_take) phase_q <= PH_POLL;
        PH_POLL: if (rsp_take) phase_q <= rsp_ack ? PH_PREAD : PH_PSTOP;
        PH_PSTOP: if (rsp_take) begin
          if (poll_spent) begin
            done_q  <= 1'b1;
            ok_q    <= 1'b0;
            phase_q <= PH_IDLE;
          end else begin
            phase_q <= PH_POLL;
          end
        end
        PH_PREAD: if (rsp_take) begin
          if (rem_q == '0) begin
            done_q  <= 1'b1;
            ok_q    <= 1'b1;
            phase_q <= PH_IDLE;
          end else begin
            chk_q   <= chunk_of(rem_q);
            phase_q <= PH_ADDR;
          end
        end
        PH_FSTOP: if (rsp_take) begin
          done_q  <= 1'b1;
          ok_q    <= 1'b0;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R11: a pending command keeps its fields until taken
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && phase_q != PH_WDATA
      |=> cmd_valid && $stable(cmd_byte) && $stable(cmd_kind) && $stable(cmd_last));

  // R11: a pending read byte keeps its value until taken
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R13: nothing is offered while idle
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !rd_valid && !wr_ready);

  // R12: completion always lands with the block idle
  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4: a refused address, offset or data byte leads straight to STOP
  a_r4_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && !rsp_ack &&
    (phase_q == PH_ADDR || phase_q == PH_OFF || phase_q == PH_RADDR || phase_q == PH_WDATA)
      |=> cmd_valid && cmd_kind == 2'd2);

  // R9: a zero-length request finishes on the next cycle with success
  a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && go && xfer_len == '0 |=> done && ok && !busy);

endmodule

// File: tb/test_i2cblk_seq.sv
module test_i2cblk_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LAT   = 2;
  localparam int CHNK  = 4;
  localparam int MAXP  = 3;
  localparam int GAP   = 5;

  typedef struct {
    int         kind;
    bit         start;
    bit         last;
    logic [7:0] b;
    bit         ack;
    logic [7:0] rb;
    bit         gap;
    string      req;
  } ent_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic is_read = 1'b0;
  logic legacy = 1'b0;
  logic [6:0] dev_addr = '0;
  logic [7:0] reg_off = '0;
  logic [7:0] xfer_len = '0;
  logic busy, done, ok;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [7:0] wr_data = '0;
  logic rd_valid;
  logic rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic cmd_valid;
  logic cmd_ready = 1'b0;
  logic [1:0] cmd_kind;
  logic cmd_start, cmd_last;
  logic [7:0] cmd_byte;
  logic rsp_valid = 1'b0;
  logic rsp_ack = 1'b0;
  logic [7:0] rsp_byte = '0;

  i2cblk_seq #(.LEN_W(8), .CHUNK(CHNK), .MAX_POLL(MAXP), .GAP_CYCLES(GAP)) i_i2cblk_seq (
    .clk, .rst_n, .go, .is_read, .legacy, .dev_addr, .reg_off, .xfer_len,
    .busy, .done, .ok, .wr_valid, .wr_ready, .wr_data, .rd_valid, .rd_ready, .rd_data,
    .cmd_valid, .cmd_ready, .cmd_kind, .cmd_start, .cmd_last, .cmd_byte,
    .rsp_valid, .rsp_ack, .rsp_byte
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  ent_t exq[$];
  logic [7:0] exp_rd[$];
  logic [7:0] wq[$];
  bit exp_ok;
  int exp_wcons;
  int wcons = 0;
  int done_seen = 0;
  bit done_ok = 1'b0;
  int done_cyc = 0;
  int ncmds = 0;
  int last_rsp_cyc = 0;

  bit p_cmd = 0, p_wd = 0, p_rd = 0;
  int s_kind; bit s_start, s_last; logic [7:0] s_byte, s_rd;
  bit rsp_pend = 0; int rsp_cnt = 0; ent_t cur;

  task automatic chk(bit cond, string req, string what, int act, int expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic push(int k, bit s, bit l, logic [7:0] b, bit a, logic [7:0] rb, bit g, string r);
    ent_t e;
    e.kind = k; e.start = s; e.last = l; e.b = b; e.ack = a; e.rb = rb; e.gap = g; e.req = r;
    exq.push_back(e);
  endtask

  // Bench-side engine and target: compares every accepted command with the expectation
  always @(negedge clk) begin
    cyc++;
    if (p_cmd) begin
      ncmds++;
      if (exq.size() == 0) begin
        chk(1'b0, "R11", "unexpected command kind", s_kind, -1);
      end else begin
        cur = exq.pop_front();
        chk(s_kind == cur.kind, cur.req, "cmd_kind", s_kind, cur.kind);
        chk(s_start == cur.start, cur.req, "cmd_start", int'(s_start), int'(cur.start));
        if (cur.kind == 1) chk(s_last == cur.last, cur.req, "cmd_last", int'(s_last), int'(cur.last));
        if (cur.kind == 0) chk(s_byte == cur.b, cur.req, "cmd_byte", s_byte, cur.b);
        if (cur.gap) chk(cyc - 1 - last_rsp_cyc >= GAP, "R1", "gap cycles", cyc - 1 - last_rsp_cyc, GAP);
        rsp_pend = 1; rsp_cnt = LAT;
      end
    end
    if (p_wd) begin
      void'(wq.pop_front());
      wcons++;
    end
    if (p_rd) begin
      if (exp_rd.size() == 0) chk(1'b0, "R7", "unexpected read byte", s_rd, -1);
      else begin
        logic [7:0] x;
        x = exp_rd.pop_front();
        chk(s_rd == x, "R3", "rd_data", s_rd, x);
      end
    end
    rsp_valid = 1'b0;
    if (rsp_pend) begin
      if (rsp_cnt == 0) begin
        rsp_valid = 1'b1; rsp_ack = cur.ack; rsp_byte = cur.rb;
        rsp_pend = 0; last_rsp_cyc = cyc;
      end else rsp_cnt--;
    end
    cmd_ready = (cyc % 3) != 0;
    rd_ready  = (cyc % 4) != 1;
    if (wq.size() == 0) wr_valid = 1'b0;
    else if (wr_valid || (cyc % 5) != 2) begin
      wr_valid = 1'b1; wr_data = wq[0];
    end
    #1;
    p_cmd = cmd_valid && cmd_ready;
    s_kind = int'(cmd_kind); s_start = cmd_start; s_last = cmd_last; s_byte = cmd_byte;
    p_wd = wr_valid && wr_ready;
    p_rd = rd_valid && rd_ready; s_rd = rd_data;
    if (done) begin done_seen++; done_ok = ok; done_cyc = cyc; end
  end

  task automatic gen_read(bit leg, logic [6:0] dev, logic [7:0] off, int len, int nack_stage);
    string r;
    r = leg ? "R2" : "R1";
    exp_ok = 1'b0; exp_wcons = 0;
    if (leg) begin
      push(0, 1, 0, {off[6:0], 1'b1}, nack_stage != 1, 0, 0, r);
      if (nack_stage == 1) begin push(2, 0, 0, 0, 1, 0, 0, "R4"); return; end
    end else begin
      push(0, 1, 0, {dev, 1'b0}, nack_stage != 1, 0, 0, r);
      if (nack_stage == 1) begin push(2, 0, 0, 0, 1, 0, 0, "R4"); return; end
      push(0, 0, 0, off, nack_stage != 2, 0, 0, r);
      if (nack_stage == 2) begin push(2, 0, 0, 0, 1, 0, 0, "R4"); return; end
      push(0, 1, 0, {dev, 1'b1}, nack_stage != 3, 0, 1, r);
      if (nack_stage == 3) begin push(2, 0, 0, 0, 1, 0, 0, "R4"); return; end
    end
    for (int i = 0; i < len; i++) begin
      logic [7:0] v;
      v = 8'h31 + 8'(i * 29) ^ {1'b0, dev};
      push(1, 0, i == len - 1, 0, 1, v, 0, "R3");
      exp_rd.push_back(v);
    end
    exp_ok = 1'b1;
  endtask

  task automatic gen_write(bit leg, logic [6:0] dev, logic [7:0] off, int len, int polls, int nack_idx);
    int rem = len; int idx = 0; logic [7:0] o = off;
    exp_ok = 1'b0; exp_wcons = 0;
    for (int i = 0; i < len; i++) wq.push_back(8'hA0 + 8'(i * 13));
    while (rem > 0) begin
      int n;
      n = (rem > CHNK) ? CHNK : rem;
      if (leg) push(0, 1, 0, {o[6:0], 1'b0}, 1, 0, 0, "R10");
      else begin
        push(0, 1, 0, {dev, 1'b0}, 1, 0, 0, "R5");
        push(0, 0, 0, o, 1, 0, 0, "R5");
      end
      for (int i = 0; i < n; i++) begin
        push(0, 0, 0, 8'hA0 + 8'(idx * 13), idx != nack_idx, 0, 0, "R8");
        exp_wcons++;
        if (idx == nack_idx) begin push(2, 0, 0, 0, 1, 0, 0, "R8"); return; end
        idx++;
      end
      o = o + 8'(n); rem -= n;
      push(2, 0, 0, 0, 1, 0, 0, "R5");
      for (int p = 0; p < polls && p < MAXP; p++) begin
        push(0, 1, 0, {dev, 1'b1}, 0, 0, 0, "R6");
        push(2, 0, 0, 0, 1, 0, 0, "R6");
      end
      if (polls >= MAXP) return;
      push(0, 1, 0, {dev, 1'b1}, 1, 0, 0, "R6");
      push(1, 0, 1, 0, 1, 8'hEE, 0, "R7");
    end
    exp_ok = 1'b1;
  endtask

  task automatic run_xfer(bit rd, bit leg, logic [6:0] dev, logic [7:0] off, int len, string req, int poke);
    int d0; int w;
    d0 = done_seen; wcons = 0; w = 0;
    @(negedge clk); #2;
    is_read = rd; legacy = leg; dev_addr = dev; reg_off = off; xfer_len = 8'(len); go = 1'b1;
    @(negedge clk); #2;
    go = 1'b0;
    while (done_seen == d0 && w < 3000) begin
      @(negedge clk); #2; w++;
      if (poke > 0 && w == poke) begin
        dev_addr = 7'h11; xfer_len = 8'd0; go = 1'b1;
        @(negedge clk); #2; go = 1'b0;
      end
    end
    chk(w < 3000, req, "done timeout", w, 3000);
    repeat (3) @(negedge clk);
    #2;
    chk(done_seen == d0 + 1, (poke > 0) ? "R12" : req, "done count", done_seen - d0, 1);
    chk(done_ok == exp_ok, req, "ok", int'(done_ok), int'(exp_ok));
    chk(exq.size() == 0, req, "commands left", exq.size(), 0);
    chk(exp_rd.size() == 0, "R3", "read bytes left", exp_rd.size(), 0);
    chk(wcons == exp_wcons, req, "write bytes taken", wcons, exp_wcons);
    exq.delete(); exp_rd.delete(); wq.delete();
  endtask

  task automatic run_zero(bit rd);
    int d0; int gc; int c0;
    gen_read(0, 7'h20, 8'h00, 0, 0);
    exq.delete(); exp_rd.delete();
    d0 = done_seen; c0 = ncmds;
    @(negedge clk); #2;
    is_read = rd; legacy = 1'b0; xfer_len = 8'd0; go = 1'b1; gc = cyc;
    @(negedge clk); #2;
    go = 1'b0;
    repeat (4) @(negedge clk);
    #2;
    chk(done_seen == d0 + 1, "R9", "done count", done_seen - d0, 1);
    chk(done_cyc == gc + 1, "R9", "done cycle", done_cyc - gc, 1);
    chk(done_ok == 1'b1, "R9", "ok", int'(done_ok), 1);
    chk(ncmds == c0, "R9", "commands issued", ncmds - c0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(negedge clk);
        chk(1'b0, "R13", "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    join_none
    repeat (4) @(negedge clk);
    #2;
    chk(!busy && !done, "R13", "idle after reset", {busy, done}, 0);
    chk(!cmd_valid && !rd_valid && !wr_ready, "R13", "valid outputs", {cmd_valid, rd_valid, wr_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!busy && !cmd_valid, "R13", "idle after release", {busy, cmd_valid}, 0);

    gen_read(0, 7'h50, 8'h10, 3, 0);          run_xfer(1, 0, 7'h50, 8'h10, 3, "R1", 0);
    gen_read(1, 7'h00, 8'h25, 2, 0);          run_xfer(1, 1, 7'h00, 8'h25, 2, "R2", 0);
    gen_read(0, 7'h51, 8'h04, 2, 1);          run_xfer(1, 0, 7'h51, 8'h04, 2, "R4", 0);
    gen_read(0, 7'h52, 8'h05, 2, 2);          run_xfer(1, 0, 7'h52, 8'h05, 2, "R4", 0);
    gen_read(0, 7'h53, 8'h06, 2, 3);          run_xfer(1, 0, 7'h53, 8'h06, 2, "R4", 0);
    gen_write(0, 7'h3C, 8'hFE, 6, 2, -1);     run_xfer(0, 0, 7'h3C, 8'hFE, 6, "R5", 0);
    gen_write(1, 7'h00, 8'h10, 5, 0, -1);     run_xfer(0, 1, 7'h00, 8'h10, 5, "R10", 0);
    gen_write(0, 7'h3D, 8'h40, 2, MAXP, -1);  run_xfer(0, 0, 7'h3D, 8'h40, 2, "R6", 0);
    gen_write(0, 7'h3E, 8'h80, 3, 0, 1);      run_xfer(0, 0, 7'h3E, 8'h80, 3, "R8", 0);
    run_zero(1);
    run_zero(0);
    gen_read(0, 7'h44, 8'h77, 4, 0);          run_xfer(1, 0, 7'h44, 8'h77, 4, "R12", 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule